// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register front end of a three-channel interval timer. A 2-bit address picks either one of the three channel count ports (addresses 0, 1 and 2) or the control port (address 3). Writes to the control port configure a channel: its byte access pattern, its counting mode and its binary/decimal flag. The same port also issues snapshot commands. Writes to a channel port assemble a 16-bit initial count and hand it to that channel as a one-cycle load pulse.

Reads of a channel port return, in priority order, a held status byte, then a held count snapshot, then the live count coming back from the channel. The live count is delivered low byte, high byte, or alternating between the two, depending on the access pattern. The counting channels sit outside this block. They supply their live 16-bit count and output level, and they take the load pulses, modes and flags.

Reads and writes have separate address ports, so a host can read one register while it writes another in the same cycle.

Top module: `itc_regif`

## Requirements
- R1: After reset every channel has counting mode 0, flag 0 and access pattern "low byte only". No snapshot is held, no load pulse is active, and `rdata` is 0.
- R2: A control write whose bits 7:6 are 0 to 2 and whose bits 5:4 are non-zero configures that channel. Bits 5:4 give the access pattern: 1 = low byte only, 2 = high byte only, 3 = low then high. Bits 3:1 give the counting mode, where 6 and 7 become 2 and 3. Bit 0 gives the flag. Mode and flag appear on `ch_mode`/`ch_bcd` one cycle after the write.
- R3: In low-only access a channel write loads {8'h00, byte}. In high-only access it loads {byte, 8'h00}.
- R4: In low-then-high access the first channel write only stores the byte, and the second loads {second, first}. A configuring control write to that channel restarts both its write and its read byte order at the low byte.
- R5: Each load raises that channel's bit of `ld_stb` for exactly the cycle after the write, with the value on its `ld_val` slice. At most one bit of `ld_stb` is high at a time.
- R6: A control write with bits 5:4 = 0 snapshots the channel's live count at that edge, marked with the current access pattern. Reads then return: low only → low byte; high only → high byte; low then high → low byte, then high byte. Then the snapshot is released.
- R7: A count or status snapshot request for a channel that already holds an unread one of that kind is ignored, and the held value is kept.
- R8: A control write with bits 7:6 = 3 is a read-back command. Bit 1, 2 or 3 selects channel 0, 1 or 2. Bit 5 low snapshots the count and bit 4 low snapshots the status of each selected channel.
- R9: The status byte is {output level, 0, access pattern[1:0], mode[2:0], flag}, taken at the command edge.
- R10: A channel read returns a held status first and releases only that. A held count comes next. Only with nothing held is the live count returned.
- R11: With nothing held, a live read returns the low byte (low-only), the high byte (high-only), or alternately low then high (low-then-high).
- R12: `rdata` updates one cycle after `rd_en`. A read of address 3 returns 0 and changes nothing.
- R13: When a read and a control write touch the same channel in one cycle, the read is served from, and releases, the old state first. The snapshot request is then judged against the released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (3 = control) |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rdata | output | 8 | Read byte, registered |
| live_cnt | input | 48 | Live 16-bit count of each channel |
| out_lvl | input | 3 | Output level of each channel |
| ld_stb | output | 3 | One-cycle count load pulse per channel |
| ld_val | output | 48 | Loaded 16-bit value per channel |
| ch_mode | output | 9 | 3-bit counting mode per channel |
| ch_bcd | output | 3 | Decimal counting flag per channel |

## Verification
Two functions can meet in one cycle: a read that releases a held byte of a channel, and a control write that asks the same channel for a fresh snapshot. The bench provokes this by arming a count snapshot, then driving a read of that channel together with a new counter-latch command. It also runs a long stretch of random traffic on both address ports. Every cycle is judged against a behavioural model that serves the read first and then decides whether the new snapshot is accepted.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m > 3'd5) ? (m - 3'd4) : m;
  endfunction
endpackage

// File: rtl/itc_cmd_dec.sv
module itc_cmd_dec #(
  parameter int NCH = 3
) (
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [7:0]     wdata,
  output logic [NCH-1:0] cfg_we,
  output logic [NCH-1:0] cnt_req,
  output logic [NCH-1:0] sts_req,
  output logic [NCH-1:0] data_we,
  output logic [1:0]     cfg_acc,
  output logic [2:0]     cfg_mode,
  output logic           cfg_bcd
);
  logic       ctl_wr;
  logic       rb_cmd;
  logic [1:0] sel;

  assign ctl_wr   = wr_en && (wr_addr == 2'd3);
  assign sel      = wdata[7:6];
  assign rb_cmd   = ctl_wr && (sel == 2'd3);
  assign cfg_acc  = wdata[5:4];
  assign cfg_mode = wdata[3:1];
  assign cfg_bcd  = wdata[0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    logic hit;
    assign hit         = ctl_wr && (sel == 2'(ch));
    assign cfg_we[ch]  = hit && (wdata[5:4] != 2'd0);
    assign cnt_req[ch] = (hit && (wdata[5:4] == 2'd0)) ||
                         (rb_cmd && wdata[ch+1] && !wdata[5]);
    assign sts_req[ch] = rb_cmd && wdata[ch+1] && !wdata[4];
    assign data_we[ch] = wr_en && (wr_addr == 2'(ch));
  end
endmodule

// File: rtl/itc_chan_port.sv
module itc_chan_port
  import itc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_acc,
  input  logic [2:0]  cfg_mode,
  input  logic        cfg_bcd,
  input  logic        cnt_req,
  input  logic        sts_req,
  input  logic        data_we,
  input  logic        data_rd,
  input  logic [7:0]  wdata,
  input  logic [15:0] live,
  input  logic        out_now,
  output logic [7:0]  rd_byte,
  output logic        ld_stb,
  output logic [15:0] ld_val,
  output logic [2:0]  mode,
  output logic        bcd
);
  acc_e        acc_q, acc_d;
  acc_e        chold_q, chold_d;
  logic [2:0]  mode_q, mode_d;
  logic        bcd_q, bcd_d;
  logic        rtog_q, rtog_d;
  logic        wtog_q, wtog_d;
  logic [7:0]  wlo_q, wlo_d;
  logic        sheld_q, sheld_d;
  logic [7:0]  sts_q, sts_d;
  logic [15:0] lat_q, lat_d;
  logic        stb_q, stb_d;
  logic [15:0] val_q, val_d;

  // read byte from current state
  always_comb begin
    if (sheld_q) begin
      rd_byte = sts_q;
    end else if (chold_q != ACC_NONE) begin
      rd_byte = (chold_q == ACC_HI) ? lat_q[15:8] : lat_q[7:0];
    end else begin
      case (acc_q)
        ACC_HI:   rd_byte = live[15:8];
        ACC_WORD: rd_byte = rtog_q ? live[15:8] : live[7:0];
        default:  rd_byte = live[7:0];
      endcase
    end
  end

  // next state: read consumption, then configuration, then snapshot requests
  always_comb begin
    acc_d   = acc_q;
    chold_d = chold_q;
    mode_d  = mode_q;
    bcd_d   = bcd_q;
    rtog_d  = rtog_q;
    wtog_d  = wtog_q;
    wlo_d   = wlo_q;
    sheld_d = sheld_q;
    sts_d   = sts_q;
    lat_d   = lat_q;
    stb_d   = 1'b0;
    val_d   = val_q;

    if (data_rd) begin
      if (sheld_q) begin
        sheld_d = 1'b0;
      end else if (chold_q != ACC_NONE) begin
        chold_d = (chold_q == ACC_WORD) ? ACC_HI : ACC_NONE;
      end else if (acc_q == ACC_WORD) begin
        rtog_d = !rtog_q;
      end
    end

    if (cfg_we) begin
      acc_d  = acc_e'(cfg_acc);
      mode_d = fold_mode(cfg_mode);
      bcd_d  = cfg_bcd;
      rtog_d = 1'b0;
      wtog_d = 1'b0;
    end

    if (cnt_req && (chold_d == ACC_NONE)) begin
      chold_d = acc_q;
      lat_d   = live;
    end

    if (sts_req && !sheld_d) begin
      sheld_d = 1'b1;
      sts_d   = {out_now, 1'b0, acc_q, mode_q, bcd_q};
    end

    if (data_we) begin
      case (acc_q)
        ACC_LO: begin
          stb_d = 1'b1;
          val_d = {8'h00, wdata};
        end
        ACC_HI: begin
          stb_d = 1'b1;
          val_d = {wdata, 8'h00};
        end
        ACC_WORD: begin
          if (!wtog_q) begin
            wlo_d  = wdata;
            wtog_d = 1'b1;
          end else begin
            stb_d  = 1'b1;
            val_d  = {wdata, wlo_q};
            wtog_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_LO;
      chold_q <= ACC_NONE;
      mode_q  <= 3'd0;
      bcd_q   <= 1'b0;
      rtog_q  <= 1'b0;
      wtog_q  <= 1'b0;
      wlo_q   <= 8'h00;
      sheld_q <= 1'b0;
      sts_q   <= 8'h00;
      lat_q   <= 16'h0000;
      stb_q   <= 1'b0;
      val_q   <= 16'h0000;
    end else begin
      acc_q   <= acc_d;
      chold_q <= chold_d;
      mode_q  <= mode_d;
      bcd_q   <= bcd_d;
      rtog_q  <= rtog_d;
      wtog_q  <= wtog_d;
      wlo_q   <= wlo_d;
      sheld_q <= sheld_d;
      sts_q   <= sts_d;
      lat_q   <= lat_d;
      stb_q   <= stb_d;
      val_q   <= val_d;
    end
  end

  assign ld_stb = stb_q;
  assign ld_val = val_q;
  assign mode   = mode_q;
  assign bcd    = bcd_q;

  AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(data_we)); // R5
  AST_WORD_FIRST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !cfg_we && (acc_q == ACC_WORD) && !wtog_q) |=> !stb_q); // R4
  AST_HELD_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((chold_q != ACC_NONE) && !data_rd) |=> $stable(lat_q)); // R7
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && sheld_q && !cnt_req) |=> $stable(chold_q)); // R10
endmodule

// File: rtl/itc_rd_mux.sv
module itc_rd_mux #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [1:0]     rd_addr,
  input  logic [NCH*8-1:0] rd_bytes,
  output logic [7:0]     rdata
);
  logic [7:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = 8'h00;
      for (int ch = 0; ch < NCH; ch++) begin
        if (rd_addr == 2'(ch)) rdata_d = rd_bytes[ch*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= 8'h00;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == 2'd3)) |=> (rdata == 8'h00)); // R12
  AST_NO_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R12
endmodule

// File: rtl/itc_regif.sv
module itc_regif #(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wdata,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rdata,
  input  logic [NCH*16-1:0] live_cnt,
  input  logic [NCH-1:0]   out_lvl,
  output logic [NCH-1:0]   ld_stb,
  output logic [NCH*16-1:0] ld_val,
  output logic [NCH*3-1:0] ch_mode,
  output logic [NCH-1:0]   ch_bcd
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  logic [NCH-1:0]        cfg_we, cnt_req, sts_req, data_we, data_rd;
  logic [1:0]            cfg_acc;
  logic [2:0]            cfg_mode;
  logic                  cfg_bcd;
  logic [NCH*BYTE_W-1:0] rd_bytes;

  itc_cmd_dec #(.NCH(NCH)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .cfg_we(cfg_we), .cnt_req(cnt_req), .sts_req(sts_req), .data_we(data_we),
    .cfg_acc(cfg_acc), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign data_rd[ch] = rd_en && (rd_addr == 2'(ch));
    itc_chan_port u_port (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we[ch]), .cfg_acc(cfg_acc), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
      .cnt_req(cnt_req[ch]), .sts_req(sts_req[ch]),
      .data_we(data_we[ch]), .data_rd(data_rd[ch]), .wdata(wdata),
      .live(live_cnt[ch*CNT_W +: CNT_W]), .out_now(out_lvl[ch]),
      .rd_byte(rd_bytes[ch*BYTE_W +: BYTE_W]),
      .ld_stb(ld_stb[ch]), .ld_val(ld_val[ch*CNT_W +: CNT_W]),
      .mode(ch_mode[ch*3 +: 3]), .bcd(ch_bcd[ch])
    );
  end

  itc_rd_mux #(.NCH(NCH)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_bytes(rd_bytes), .rdata(rdata)
  );

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb)); // R5
  AST_MODE_TRACKS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we[0] && (wdata[3:1] == 3'd7)) |=> (ch_mode[2:0] == 3'd3)); // R2
endmodule

// File: tb/itc_regif_tb_top.sv
module itc_regif_tb_top;
  localparam int NCH = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic wr_en, rd_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wdata, rdata;
  logic [NCH*16-1:0] live_cnt, ld_val;
  logic [NCH-1:0] out_lvl, ld_stb, ch_bcd;
  logic [NCH*3-1:0] ch_mode;
  logic [15:0] lc [NCH];

  itc_regif #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata),
    .live_cnt(live_cnt), .out_lvl(out_lvl), .ld_stb(ld_stb), .ld_val(ld_val),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  // channel stub: free-running down counters, level from bit 4
  for (genvar ch = 0; ch < NCH; ch++) begin : g_stub
    assign live_cnt[ch*16 +: 16] = lc[ch];
    assign out_lvl[ch] = lc[ch][4];
  end
  initial begin
    lc[0] = 16'h1234; lc[1] = 16'hA5F0; lc[2] = 16'h0F0F;
    forever begin
      @(negedge clk); #2;
      for (int ch = 0; ch < NCH; ch++) lc[ch] = lc[ch] - 16'(ch + 1);
    end
  end

  // behavioural reference model
  int m_acc[NCH], m_mode[NCH], m_bcd[NCH], m_rtog[NCH], m_wtog[NCH], m_wlo[NCH];
  int m_sheld[NCH], m_sts[NCH], m_chold[NCH], m_lat[NCH];
  int e_rdata;
  int e_stb[NCH], e_val[NCH];

  task automatic snap_count(int ch);
    if (m_chold[ch] == 0) begin
      m_chold[ch] = m_acc[ch];
      m_lat[ch] = int'(lc[ch]);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int ch = 0; ch < NCH; ch++) begin
        m_acc[ch] = 1; m_mode[ch] = 0; m_bcd[ch] = 0; m_rtog[ch] = 0; m_wtog[ch] = 0;
        m_wlo[ch] = 0; m_sheld[ch] = 0; m_sts[ch] = 0; m_chold[ch] = 0; m_lat[ch] = 0;
        e_stb[ch] = 0; e_val[ch] = 0;
      end
      e_rdata = 0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) e_stb[ch] = 0;
      if (rd_en) begin
        if (rd_addr == 2'd3) e_rdata = 0;
        else begin
          int c;
          c = int'(rd_addr);
          if (m_sheld[c] != 0) begin
            e_rdata = m_sts[c]; m_sheld[c] = 0;
          end else if (m_chold[c] != 0) begin
            if (m_chold[c] == 2) begin e_rdata = (m_lat[c] >> 8) & 255; m_chold[c] = 0; end
            else begin e_rdata = m_lat[c] & 255; m_chold[c] = (m_chold[c] == 3) ? 2 : 0; end
          end else begin
            int lv;
            lv = int'(lc[c]);
            if (m_acc[c] == 2) e_rdata = (lv >> 8) & 255;
            else if (m_acc[c] == 3) begin
              e_rdata = (m_rtog[c] != 0) ? ((lv >> 8) & 255) : (lv & 255);
              m_rtog[c] = 1 - m_rtog[c];
            end else e_rdata = lv & 255;
          end
        end
      end
      if (wr_en) begin
        int v;
        v = int'(wdata);
        if (wr_addr == 2'd3) begin
          int s;
          s = v >> 6;
          if (s == 3) begin
            for (int ch = 0; ch < NCH; ch++) begin
              if (((v >> (ch + 1)) & 1) != 0) begin
                if (((v >> 5) & 1) == 0) snap_count(ch);
                if (((v >> 4) & 1) == 0 && m_sheld[ch] == 0) begin
                  m_sheld[ch] = 1;
                  m_sts[ch] = (int'(out_lvl[ch]) << 7) | (m_acc[ch] << 4) | (m_mode[ch] << 1) | m_bcd[ch];
                end
              end
            end
          end else begin
            int a, md;
            a = (v >> 4) & 3;
            if (a == 0) snap_count(s);
            else begin
              md = (v >> 1) & 7;
              if (md > 5) md = md - 4;
              m_acc[s] = a; m_mode[s] = md; m_bcd[s] = v & 1; m_rtog[s] = 0; m_wtog[s] = 0;
            end
          end
        end else begin
          int c;
          c = int'(wr_addr);
          if (m_acc[c] == 1) begin e_stb[c] = 1; e_val[c] = v; end
          else if (m_acc[c] == 2) begin e_stb[c] = 1; e_val[c] = v << 8; end
          else if (m_wtog[c] != 0) begin e_stb[c] = 1; e_val[c] = (v << 8) | m_wlo[c]; m_wtog[c] = 0; end
          else begin m_wlo[c] = v; m_wtog[c] = 1; end
        end
      end
    end
  end

  // checking
  int n_tests = 0, n_fail = 0;
  bit armed = 0, done = 0;
  string phase = "R1";

  task automatic chk(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("rdata", int'(rdata), e_rdata);
      for (int ch = 0; ch < NCH; ch++) begin
        chk($sformatf("ld_stb[%0d]", ch), int'(ld_stb[ch]), e_stb[ch]);
        if (e_stb[ch] != 0) chk($sformatf("ld_val[%0d]", ch), int'(ld_val[ch*16 +: 16]), e_val[ch]);
        chk($sformatf("mode[%0d]", ch), int'(ch_mode[ch*3 +: 3]), m_mode[ch]);
        chk($sformatf("bcd[%0d]", ch), int'(ch_bcd[ch]), m_bcd[ch]);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic cyc(bit w, logic [1:0] wa, logic [7:0] d, bit r, logic [1:0] ra);
    @(negedge clk); #1;
    wr_en = w; wr_addr = wa; wdata = d; rd_en = r; rd_addr = ra;
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d); cyc(1, a, d, 0, 2'd0); endtask
  task automatic rd(logic [1:0] a); cyc(0, 2'd0, 8'h00, 1, a); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 2'd0, 8'h00, 0, 2'd0); endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired in phase %s actual=running expected=finished", phase);
    report();
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst_n = 1'b1;
    armed = 1;
    phase = "R1"; idle(2);
    phase = "R2"; wr(3, 8'b00_01_010_1); wr(3, 8'b01_10_111_0); wr(3, 8'b10_11_110_0); idle(1);
    phase = "R3"; wr(0, 8'h3C); wr(1, 8'h7E); idle(1);
    phase = "R4"; wr(2, 8'h11); wr(2, 8'h22); wr(2, 8'h33); wr(3, 8'b10_11_000_0);
    wr(2, 8'h44); wr(2, 8'h55); idle(1);
    phase = "R5"; wr(0, 8'h01); wr(0, 8'h02); wr(1, 8'h03); idle(2);
    phase = "R11"; rd(0); rd(1); rd(2); rd(2); rd(2); idle(1);
    phase = "R6"; wr(3, 8'b10_00_0000); idle(3); rd(2); rd(2); rd(2); idle(1);
    phase = "R7"; wr(3, 8'b00_00_0000); idle(2); wr(3, 8'b00_00_0000); idle(2); rd(0); rd(0); idle(1);
    phase = "R9"; wr(3, 8'b11_00_1010); idle(2);
    phase = "R10"; rd(0); rd(0); rd(0); rd(2); rd(2); rd(2); idle(1);
    phase = "R8"; wr(3, 8'b11_10_0100); idle(1); rd(1); wr(3, 8'b11_01_0100); idle(2); rd(1); rd(1); idle(1);
    phase = "R12"; rd(3); idle(1); wr(3, 8'b11_00_1110); rd(3); idle(1);
    phase = "R13"; wr(3, 8'b01_00_0000); idle(2);
    cyc(1, 2'd3, 8'b01_00_0000, 1, 2'd1); idle(2); rd(1); rd(1); idle(1);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      cyc(($urandom % 5) < 2, 2'($urandom), d, ($urandom % 5) < 2, 2'($urandom));
    end
    idle(3);
    report();
  end
endmodule